// File: doc/BRIEF.md
# Static Memory Bank Read Timing Controller

This block runs read cycles on an asynchronous external static-memory or peripheral bus for one bank. An internal requester offers a word address over a valid/ready handshake. The controller then drives the external address, an active-low chip select and an active-low output enable. Each phase of the cycle lasts a number of clock cycles set by per-bank configuration inputs. Every beat it reads returns as a data word together with a one-cycle done pulse.

The configuration holds six phase lengths, a data-width select (8 or 16 bits) and a page-mode enable. The controller latches the whole configuration when it accepts a request, so later changes reach only the next request. Without page mode, a request reads one item. With page mode, a request reads four items from the same aligned group of four words. The first item uses the full access time and the other three use the shorter page access time. Chip select and output enable stay low between these four beats.

The control is a seven-state machine:
- `ST_IDLE` has ready high.
- `ST_ASETUP` holds the address before chip select falls.
- `ST_CS2OE` has chip select low and output enable still high.
- `ST_ACCESS` is the first access with output enable low.
- `ST_PAGE` covers each later page beat.
- `ST_CSHOLD` has output enable high and chip select still low.
- `ST_AHOLD` has chip select high while the address is held.

The transitions follow that order:
- IDLE to ASETUP.
- ASETUP to CS2OE.
- CS2OE to ACCESS.
- ACCESS to PAGE, or ACCESS to CSHOLD.
- PAGE to PAGE, or PAGE to CSHOLD.
- CSHOLD to AHOLD.
- AHOLD to IDLE.

A phase programmed to zero is passed over, so the machine moves to the next phase that has a non-zero length. This adds the shortcut transitions IDLE to CS2OE and IDLE to ACCESS, ASETUP to ACCESS, ACCESS or PAGE to AHOLD or IDLE, and CSHOLD to IDLE.

Top module: `smb_read_ctrl`

## Requirements
- R1: After reset, `mem_cs_n` and `mem_oe_n` are 1, `req_ready` is 1 and `rsp_done` is 0.
- R2: After acceptance, the cycle runs in this order:
  - the address alone is driven for `cfg_t_asetup` cycles;
  - then `mem_cs_n` is 0 with `mem_oe_n` 1 for `cfg_t_cs2oe` cycles;
  - then both are 0.
- R3: The first access phase (`mem_oe_n` low) lasts `cfg_t_acc` + 1 cycles. `cfg_t_acc` is 5 bits wide (0 to 31), and the other timing fields are 4 bits wide (0 to 15).
- R4: After the last access, `mem_oe_n` is 1 with `mem_cs_n` 0 for `cfg_t_cshold` cycles. Then `mem_cs_n` is 1 with the address unchanged for `cfg_t_ahold` cycles. Then the controller is idle.
- R5: A value of 0 in `cfg_t_asetup`, `cfg_t_cs2oe`, `cfg_t_cshold` or `cfg_t_ahold` removes that phase entirely.
- R6: With `cfg_page_en` = 1, a request yields four beats. Each beat after the first keeps `mem_oe_n` and `mem_cs_n` low for `cfg_t_page` cycles, and a value of 0 counts as 1. For beat b (0 to 3), `mem_addr` equals the request address with its two low bits replaced by (low bits + b) mod 4. With `cfg_page_en` = 0, a request yields one beat.
- R7: `mem_rdata` is sampled on the last cycle of each beat's output-enable phase. `rsp_done` is high for exactly the following cycle, and `rsp_data` holds that beat's value in that cycle.
- R8: With `cfg_wide` = 1, `rsp_data` is all 16 bits of `mem_rdata`. With `cfg_wide` = 0, `rsp_data` is `{8'h00, mem_rdata[7:0]}`.
- R9: `req_ready` is 0 from the cycle after acceptance until the last address-hold cycle. `req_valid` has no effect while `req_ready` is 0.
- R10: Configuration inputs are captured at acceptance. Changes made during a transaction do not alter its waveform or data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_t_page | input | 4 | Page beat length in cycles (0 treated as 1) |
| cfg_t_ahold | input | 4 | Address hold after chip select rises |
| cfg_t_cshold | input | 4 | Chip select hold after output enable rises |
| cfg_t_acc | input | 5 | First access length minus one |
| cfg_t_cs2oe | input | 4 | Chip select to output enable setup |
| cfg_t_asetup | input | 4 | Address setup before chip select |
| cfg_wide | input | 1 | 1 = 16-bit bank, 0 = 8-bit bank |
| cfg_page_en | input | 1 | 1 = four-beat page read |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_done | output | 1 | One-cycle pulse per returned beat |
| rsp_data | output | DATA_W | Read data for the beat |
| mem_addr | output | ADDR_W | External word address |
| mem_cs_n | output | 1 | External chip select, active low |
| mem_oe_n | output | 1 | External output enable, active low |
| mem_rdata | input | DATA_W | External read data |

## Verification
The bench builds the controller with a 10-bit address and a 16-bit data path. With these sizes, the wrap of the two low page bits and the upper address bits can be seen on the pins. The external memory returns a value derived from the address only while output enable is low. Data sampled one cycle late therefore shows up as a mismatch.

The directed configurations cover:
- all-zero optional phases;
- the largest access and hold counts;
- page reads with a zero page count;
- 8-bit banks;
- configuration changes and requests made while a read is in progress.

A seeded series of configurations then mixes these settings.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int T_W   = 4;
    localparam int ACC_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASETUP,
        ST_CS2OE,
        ST_ACCESS,
        ST_PAGE,
        ST_CSHOLD,
        ST_AHOLD
    } smb_state_e;

    typedef struct packed {
        logic [T_W-1:0]   t_page;
        logic [T_W-1:0]   t_ahold;
        logic [T_W-1:0]   t_cshold;
        logic [ACC_W-1:0] t_acc;
        logic [T_W-1:0]   t_cs2oe;
        logic [T_W-1:0]   t_asetup;
        logic             wide;
        logic             page_en;
    } smb_cfg_t;

endpackage

// File: rtl/smb_phase_timer.sv
module smb_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/smb_beat_tracker.sv
module smb_beat_tracker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              advance,
    input  logic              sample,
    input  logic              wide,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat_last,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int BW     = $clog2(BEATS);
    localparam int HALF_W = DATA_W / 2;

    logic [ADDR_W-1:0] base_q;
    logic [BW-1:0]     beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (start) begin
            base_q <= base_addr;
            beat_q <= '0;
        end else if (advance) begin
            beat_q <= beat_q + BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_done <= sample;
            if (sample) begin
                if (wide) begin
                    rsp_data <= mem_rdata;
                end else begin
                    rsp_data <= {{(DATA_W-HALF_W){1'b0}}, mem_rdata[HALF_W-1:0]};
                end
            end
        end
    end

    assign mem_addr  = {base_q[ADDR_W-1:BW], base_q[BW-1:0] + beat_q};
    assign beat_last = (beat_q == BW'(BEATS-1));

    // The beat index never wraps within one request.
    assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> beat_last);

    // A done pulse always carries freshly sampled data.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(sample));

endmodule

// File: rtl/smb_read_ctrl.sv
module smb_read_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_t_page,
    input  logic [3:0]        cfg_t_ahold,
    input  logic [3:0]        cfg_t_cshold,
    input  logic [4:0]        cfg_t_acc,
    input  logic [3:0]        cfg_t_cs2oe,
    input  logic [3:0]        cfg_t_asetup,
    input  logic              cfg_wide,
    input  logic              cfg_page_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_rdata
);
    import smb_pkg::*;

    localparam int CNT_W = ACC_W;
    localparam int PAD_W = CNT_W - T_W;
    localparam int BEATS = 4;

    smb_state_e       state_q, state_d;
    smb_cfg_t         live_cfg, lat_cfg, eff_cfg;
    logic             accept, phase_end, expire, beat_last;
    logic             tmr_load, advance, sample;
    logic [CNT_W-1:0] tmr_val;

    assign live_cfg = '{t_page:   cfg_t_page,
                        t_ahold:  cfg_t_ahold,
                        t_cshold: cfg_t_cshold,
                        t_acc:    cfg_t_acc,
                        t_cs2oe:  cfg_t_cs2oe,
                        t_asetup: cfg_t_asetup,
                        wide:     cfg_wide,
                        page_en:  cfg_page_en};

    assign eff_cfg   = (state_q == ST_IDLE) ? live_cfg : lat_cfg;
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign phase_end = (state_q != ST_IDLE) && expire;

    function automatic smb_state_e after_access(input smb_cfg_t c);
        if (c.t_cshold != '0)     return ST_CSHOLD;
        else if (c.t_ahold != '0) return ST_AHOLD;
        else                      return ST_IDLE;
    endfunction

    function automatic logic [CNT_W-1:0] ext(input logic [T_W-1:0] v);
        return {{PAD_W{1'b0}}, v} - CNT_W'(1);
    endfunction

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (eff_cfg.t_asetup != '0)     state_d = ST_ASETUP;
                    else if (eff_cfg.t_cs2oe != '0) state_d = ST_CS2OE;
                    else                            state_d = ST_ACCESS;
                end
            end
            ST_ASETUP: begin
                if (phase_end) begin
                    state_d = (eff_cfg.t_cs2oe != '0) ? ST_CS2OE : ST_ACCESS;
                end
            end
            ST_CS2OE: begin
                if (phase_end) state_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (phase_end) begin
                    state_d = eff_cfg.page_en ? ST_PAGE : after_access(eff_cfg);
                end
            end
            ST_PAGE: begin
                if (phase_end) begin
                    state_d = beat_last ? after_access(eff_cfg) : ST_PAGE;
                end
            end
            ST_CSHOLD: begin
                if (phase_end) begin
                    state_d = (eff_cfg.t_ahold != '0) ? ST_AHOLD : ST_IDLE;
                end
            end
            ST_AHOLD: begin
                if (phase_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase length of the state being entered
    always_comb begin
        tmr_val = '0;
        unique case (state_d)
            ST_ASETUP: tmr_val = ext(eff_cfg.t_asetup);
            ST_CS2OE:  tmr_val = ext(eff_cfg.t_cs2oe);
            ST_ACCESS: tmr_val = eff_cfg.t_acc;
            ST_PAGE:   tmr_val = (eff_cfg.t_page == '0) ? '0 : ext(eff_cfg.t_page);
            ST_CSHOLD: tmr_val = ext(eff_cfg.t_cshold);
            ST_AHOLD:  tmr_val = ext(eff_cfg.t_ahold);
            default:   tmr_val = '0;
        endcase
    end

    assign tmr_load = accept || phase_end;
    assign advance  = phase_end && (state_d == ST_PAGE);
    assign sample   = phase_end && ((state_q == ST_ACCESS) || (state_q == ST_PAGE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_cfg <= '0;
        end else begin
            state_q <= state_d;
            if (accept) lat_cfg <= live_cfg;
        end
    end

    // Bus outputs
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_oe_n  = 1'b1;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_ASETUP: ;
            ST_CS2OE:  mem_cs_n = 1'b0;
            ST_ACCESS,
            ST_PAGE: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_CSHOLD: mem_cs_n = 1'b0;
            ST_AHOLD:  ;
            default:   ;
        endcase
    end

    smb_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    smb_beat_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .base_addr (req_addr),
        .advance   (advance),
        .sample    (sample),
        .wide      (eff_cfg.wide),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .beat_last (beat_last),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data)
    );

    assert_oe_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_cs_n);

    assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!mem_oe_n));

    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n) && !lat_cfg.page_en) |-> $stable(mem_addr));

    assert_cs_hold_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_cs_n) && !req_ready) |-> $stable(mem_addr));

endmodule

// File: tb/smb_read_ctrl_bench.sv
module smb_read_ctrl_bench;

    localparam int AW = 10;
    localparam int DW = 16;

    typedef struct {
        int  page, ahold, cshold, acc, cs2oe, asetup;
        bit  wide, page_en;
    } tcfg_t;

    typedef struct {
        bit cs, oe, rdy, done, chk_a;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } entry_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_t_page = '0, cfg_t_ahold = '0, cfg_t_cshold = '0;
    logic [4:0]    cfg_t_acc = '0;
    logic [3:0]    cfg_t_cs2oe = '0, cfg_t_asetup = '0;
    logic          cfg_wide = 1'b0, cfg_page_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rsp_done, mem_cs_n, mem_oe_n;
    logic [DW-1:0] rsp_data, mem_rdata;
    logic [AW-1:0] mem_addr;

    int     checks = 0;
    int     errors = 0;
    int     cycles = 0;
    string  cur_tag = "R1";
    entry_t q[$];
    bit     pend = 1'b0;
    logic [DW-1:0] pend_d = '0;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        logic [15:0] t;
        t = {6'b0, a};
        return (t * 16'h03B1) ^ 16'hC35A;
    endfunction

    assign mem_rdata = mem_oe_n ? 16'hDEAD : memf(mem_addr);

    smb_read_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_smb_read_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_t_page(cfg_t_page), .cfg_t_ahold(cfg_t_ahold), .cfg_t_cshold(cfg_t_cshold),
        .cfg_t_acc(cfg_t_acc), .cfg_t_cs2oe(cfg_t_cs2oe), .cfg_t_asetup(cfg_t_asetup),
        .cfg_wide(cfg_wide), .cfg_page_en(cfg_page_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_done(rsp_done), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, cur_tag, $time, act, exp);
        end
    endtask

    task automatic push(input bit cs, input bit oe, input bit rdy, input bit chka, input logic [AW-1:0] a);
        entry_t e;
        e.cs = cs; e.oe = oe; e.rdy = rdy; e.chk_a = chka; e.a = a;
        e.done = pend; e.d = pend_d;
        pend = 1'b0;
        q.push_back(e);
    endtask

    // Expected per-cycle waveform of one request, built from the requirements.
    task automatic build(input tcfg_t t, input logic [AW-1:0] A);
        logic [AW-1:0] ab;
        logic [DW-1:0] v;
        int beats, len;
        ab = A;
        beats = t.page_en ? 4 : 1;
        for (int i = 0; i < t.asetup; i++) push(1, 1, 0, 1, A);
        for (int i = 0; i < t.cs2oe; i++)  push(0, 1, 0, 1, A);
        for (int b = 0; b < beats; b++) begin
            ab  = {A[AW-1:2], 2'(A[1:0] + 2'(b))};
            len = (b == 0) ? t.acc + 1 : ((t.page == 0) ? 1 : t.page);
            for (int c = 0; c < len; c++) push(0, 0, 0, 1, ab);
            v = memf(ab);
            pend   = 1'b1;
            pend_d = t.wide ? v : {8'h00, v[7:0]};
        end
        for (int i = 0; i < t.cshold; i++) push(0, 1, 0, 1, ab);
        for (int i = 0; i < t.ahold; i++)  push(1, 1, 0, 1, ab);
        if (pend) push(1, 1, 1, 0, ab);
    endtask

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        entry_t e;
        if (rst_n) begin
            if (q.size() > 0) e = q.pop_front();
            else begin
                e.cs = 1; e.oe = 1; e.rdy = 1; e.done = 0; e.chk_a = 0; e.a = '0; e.d = '0;
            end
            chk(mem_cs_n == e.cs, "R2 cs_n", 32'(mem_cs_n), 32'(e.cs));
            chk(mem_oe_n == e.oe, "R2 oe_n", 32'(mem_oe_n), 32'(e.oe));
            chk(req_ready == e.rdy, "R9 ready", 32'(req_ready), 32'(e.rdy));
            chk(rsp_done == e.done, "R7 done", 32'(rsp_done), 32'(e.done));
            if (e.chk_a) chk(mem_addr == e.a, "R6 addr", 32'(mem_addr), 32'(e.a));
            if (e.done)  chk(rsp_data == e.d, "R8 data", 32'(rsp_data), 32'(e.d));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic apply(input tcfg_t t);
        cfg_t_page   = 4'(t.page);
        cfg_t_ahold  = 4'(t.ahold);
        cfg_t_cshold = 4'(t.cshold);
        cfg_t_acc    = 5'(t.acc);
        cfg_t_cs2oe  = 4'(t.cs2oe);
        cfg_t_asetup = 4'(t.asetup);
        cfg_wide     = t.wide;
        cfg_page_en  = t.page_en;
    endtask

    task automatic issue(input tcfg_t t, input logic [AW-1:0] A, input bit scramble, input bit poke);
        @(posedge clk); #1;
        while (q.size() != 0) begin
            @(posedge clk); #1;
        end
        apply(t);
        req_addr  = A;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        build(t, A);
        if (scramble) begin
            cfg_t_page = ~cfg_t_page; cfg_t_ahold = ~cfg_t_ahold; cfg_t_cshold = ~cfg_t_cshold;
            cfg_t_acc = ~cfg_t_acc; cfg_t_cs2oe = ~cfg_t_cs2oe; cfg_t_asetup = ~cfg_t_asetup;
            cfg_wide = ~cfg_wide; cfg_page_en = ~cfg_page_en;
        end
        if (poke) begin
            req_addr  = ~A;
            req_valid = 1'b1;
            repeat (2) @(posedge clk);
            #1 req_valid = 1'b0;
        end
        while (q.size() != 0) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    function automatic tcfg_t mk(input int pg, ah, ch, ac, co, as, input bit w, pe);
        tcfg_t t;
        t.page = pg; t.ahold = ah; t.cshold = ch; t.acc = ac;
        t.cs2oe = co; t.asetup = as; t.wide = w; t.page_en = pe;
        return t;
    endfunction

    initial begin
        int seed;
        seed = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk(mem_cs_n == 1'b1, "R1 cs_n", 32'(mem_cs_n), 32'd1);
        chk(mem_oe_n == 1'b1, "R1 oe_n", 32'(mem_oe_n), 32'd1);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(rsp_done == 1'b0, "R1 done", 32'(rsp_done), 32'd0);

        cur_tag = "R2 R3 R4 basic";
        issue(mk(0, 3, 2, 4, 3, 2, 1, 0), 10'h155, 0, 0);
        cur_tag = "R5 all optional phases zero";
        issue(mk(0, 0, 0, 0, 0, 0, 1, 0), 10'h0A3, 0, 0);
        cur_tag = "R5 only hold phases zero";
        issue(mk(0, 0, 0, 2, 1, 1, 1, 0), 10'h2F0, 0, 0);
        cur_tag = "R6 page wrap";
        issue(mk(2, 1, 1, 3, 1, 1, 1, 1), 10'h3C6, 0, 0);
        cur_tag = "R6 page count zero R8 narrow";
        issue(mk(0, 0, 0, 0, 0, 0, 0, 1), 10'h17F, 0, 0);
        cur_tag = "R8 narrow single";
        issue(mk(0, 2, 1, 5, 2, 0, 0, 0), 10'h099, 0, 0);
        cur_tag = "R3 max counts";
        issue(mk(15, 15, 15, 31, 15, 15, 1, 1), 10'h3FF, 0, 0);
        cur_tag = "R10 config changed mid-read";
        issue(mk(1, 1, 2, 3, 0, 2, 0, 0), 10'h201, 1, 0);
        cur_tag = "R9 request while busy";
        issue(mk(0, 2, 2, 6, 2, 2, 1, 0), 10'h111, 0, 1);
        cur_tag = "R7 back-to-back";
        issue(mk(0, 0, 0, 1, 0, 0, 1, 0), 10'h042, 0, 0);
        issue(mk(3, 0, 0, 0, 0, 0, 1, 1), 10'h043, 0, 0);

        cur_tag = "R2 R6 R8 seeded mix";
        for (int n = 0; n < 40; n++) begin
            tcfg_t t;
            seed = seed * 1103515245 + 12345;
            t = mk((seed >>> 4) & 15, (seed >>> 8) & 15, (seed >>> 12) & 15,
                   (seed >>> 16) & 31, (seed >>> 21) & 15, (seed >>> 25) & 15,
                   seed[2], seed[3]);
            issue(t, AW'(seed >>> 6), seed[1], 0);
        end

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule